// File: doc/BRIEF.md
# Half-Rate Word to Full-Rate Byte Gearbox

This block joins a 16-bit datapath running on a core clock to an 8-bit single-data-rate link running on a clock exactly twice as fast. On the outbound side, each word taken from the core is cut into two bytes, and the bytes leave on two back-to-back fast-clock cycles. On the inbound side, byte pairs arriving on the fast clock are joined into words and handed to the core clock domain.

Both clocks come from outside and are phase-locked. Every core rising edge lines up with a fast-clock rising edge. A toggle flop on the core clock is sampled by two fast-clock flops, so the block finds out which fast-clock cycle ends on a core edge. That fixes which byte slot each half of a word uses, and byte order stays the same after every reset. The link has no start or valid handshake. Until the phase finder has seen two core-clock toggles, the outbound byte is held at zero and inbound words are marked not valid.

Top module: `byte_gearbox`

## Requirements
- R1: While reset is asserted (low), `tx_byte_o` reads 8'h00, `rx_valid_o` reads 0 and `rx_word_o` reads 16'h0000.
- R2: After reset is released, `tx_byte_o` stays 8'h00 and `rx_valid_o` stays 0 until two core-clock toggles have been detected in the fast domain. No word given before then leaks onto the link.
- R3: With the default ordering, the low byte (bits 7:0) of a word goes out first, and the high byte (bits 15:8) goes out on the very next fast cycle.
- R4: The low byte appears on `tx_byte_o` exactly two fast-clock cycles after the core edge that captures `tx_word_i`. The high byte follows one fast cycle later. This latency never changes.
- R5: The phase finder marks exactly one fast cycle per core cycle. That fast cycle ends on a core edge, and no two marks are ever adjacent.
- R6: On receive, the byte sampled at the fast edge midway through a core cycle becomes bits 7:0. The byte sampled at the next fast edge, which coincides with a core edge, becomes bits 15:8. The joined word appears on `rx_word_o` after the following core edge.
- R7: Once `rx_valid_o` rises, it stays high until the next reset.
- R8: With `tx_byte_o` looped back to `rx_byte_i`, every word returns intact and in order, four core cycles after it is driven, for at least 1000 words in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_core | input | 1 | Core clock, half the fast clock's rate, rising edges aligned to it |
| rst_core_n | input | 1 | Synchronous active-low reset, core domain |
| clk_phy | input | 1 | Fast link clock |
| rst_phy_n | input | 1 | Synchronous active-low reset, fast domain |
| tx_word_i | input | 16 | Outbound word, captured on each core edge |
| tx_byte_o | output | 8 | Outbound byte, registered on the fast clock |
| rx_byte_i | input | 8 | Inbound byte, sampled on the fast clock |
| rx_word_o | output | 16 | Joined inbound word, core domain |
| rx_valid_o | output | 1 | Inbound word is meaningful (phase found) |

## Verification
The assertions assume three things. The two clocks keep an exact 2:1 ratio with every core rising edge on a fast rising edge. Both resets are asserted and released together. The inputs change only between the edges that sample them. The bench meets these assumptions by generating both clocks from one process, so their rising edges fall in the same time step. It drives all stimulus and both resets at fast-clock falling edges, and it samples outputs at those same falling edges. Cross-domain paths inside the block therefore always see settled data.

// File: rtl/gbx_pkg.sv
`timescale 1ns/1ps
// Shared defaults for the byte gearbox.
// Assumes: nothing; constants only.
package gbx_pkg;
    localparam int unsigned GBX_WORD_W     = 16; // core-side word width
    localparam int unsigned GBX_LOCK_EDGES = 2;  // toggles to see before lock
endpackage

// File: rtl/gbx_phase_det.sv
`timescale 1ns/1ps
// Finds the fast-clock cycle that ends on a core-clock edge.
// Assumes: clk_core is clk_phy divided by two, rising edges coincident;
// both resets asserted and released together.
module gbx_phase_det #(
    parameter int unsigned LOCK_EDGES = gbx_pkg::GBX_LOCK_EDGES
) (
    input  logic clk_core,
    input  logic rst_core_n,
    input  logic clk_phy,
    input  logic rst_phy_n,
    output logic slot_last,
    output logic locked
);
    localparam int unsigned CNT_W = $clog2(LOCK_EDGES + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(LOCK_EDGES);

    logic             core_tgl;
    logic [1:0]       smp_q;
    logic [CNT_W-1:0] seen_q;

    // Flip a marker bit on every core edge.
    always_ff @(posedge clk_core) begin
        if (!rst_core_n) core_tgl <= 1'b0;
        else             core_tgl <= ~core_tgl;
    end

    // Two-stage sampling of the marker in the fast domain.
    always_ff @(posedge clk_phy) begin
        if (!rst_phy_n) smp_q <= '0;
        else            smp_q <= {smp_q[0], core_tgl};
    end

    assign slot_last = smp_q[0] ^ smp_q[1];

    // Count marks up to the lock threshold, then hold.
    always_ff @(posedge clk_phy) begin
        if (!rst_phy_n)                          seen_q <= '0;
        else if (slot_last && seen_q != CNT_FULL) seen_q <= seen_q + 1'b1;
    end

    assign locked = (seen_q == CNT_FULL);

    assert_single_mark_R5: assert property (@(posedge clk_phy) disable iff (!rst_phy_n)
        slot_last |=> !slot_last) else $error("R5 adjacent slot marks");

    assert_lock_sticky_R2: assert property (@(posedge clk_phy) disable iff (!rst_phy_n)
        locked |=> locked) else $error("R2 lock dropped");
endmodule

// File: rtl/gbx_tx.sv
`timescale 1ns/1ps
// Outbound serializer: emits one word as two bytes on consecutive fast cycles.
// Assumes: word_in is stable across the fast edge flagged by slot_last.
module gbx_tx #(
    parameter int unsigned WORD_W    = gbx_pkg::GBX_WORD_W,
    parameter bit          LOW_FIRST = 1'b1
) (
    input  logic              clk_phy,
    input  logic              rst_phy_n,
    input  logic              slot_last,
    input  logic              locked,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W/2-1:0] tx_byte
);
    localparam int unsigned BYTE_W = WORD_W / 2;

    logic [BYTE_W-1:0] first_b, second_b, pend_q, out_q;

    // Pick the send order of the two halves.
    generate
        if (LOW_FIRST) begin : g_low_first
            assign first_b  = word_in[BYTE_W-1:0];
            assign second_b = word_in[WORD_W-1:BYTE_W];
        end else begin : g_high_first
            assign first_b  = word_in[WORD_W-1:BYTE_W];
            assign second_b = word_in[BYTE_W-1:0];
        end
    endgenerate

    // Load a new word on the core-aligned edge, else shift out the held half.
    always_ff @(posedge clk_phy) begin
        if (!rst_phy_n || !locked) begin
            out_q  <= '0;
            pend_q <= '0;
        end else if (slot_last) begin
            out_q  <= first_b;
            pend_q <= second_b;
        end else begin
            out_q  <= pend_q;
        end
    end

    assign tx_byte = out_q;

    assert_idle_zero_R2: assert property (@(posedge clk_phy) disable iff (!rst_phy_n)
        !locked |=> out_q == '0) else $error("R2 byte leaked before lock");

    assert_first_half_R3: assert property (@(posedge clk_phy) disable iff (!rst_phy_n)
        locked && slot_last |=> out_q == $past(first_b)) else $error("R3 first half wrong");

    assert_second_half_R3: assert property (@(posedge clk_phy) disable iff (!rst_phy_n)
        locked && slot_last |-> ##2 (out_q == $past(second_b, 2))) else $error("R3 second half wrong");
endmodule

// File: rtl/gbx_rx.sv
`timescale 1ns/1ps
// Inbound deserializer: joins byte pairs and hands words to the core domain.
// Assumes: rx_byte changes only between fast edges; clocks phase-locked 2:1.
module gbx_rx #(
    parameter int unsigned WORD_W    = gbx_pkg::GBX_WORD_W,
    parameter bit          LOW_FIRST = 1'b1
) (
    input  logic                clk_phy,
    input  logic                rst_phy_n,
    input  logic                clk_core,
    input  logic                rst_core_n,
    input  logic                slot_last,
    input  logic                locked,
    input  logic [WORD_W/2-1:0] rx_byte,
    output logic [WORD_W-1:0]   word_out,
    output logic                valid_out
);
    localparam int unsigned BYTE_W = WORD_W / 2;

    logic [BYTE_W-1:0] part_q;
    logic [WORD_W-1:0] joined, asm_q, word_q;
    logic              asm_v, valid_q;

    // Place the first-arriving byte according to the chosen order.
    generate
        if (LOW_FIRST) begin : g_low_first
            assign joined = {rx_byte, part_q};
            assert_join_order_R6: assert property (@(posedge clk_phy) disable iff (!rst_phy_n)
                !slot_last ##1 slot_last |=> (asm_q[BYTE_W-1:0] == $past(rx_byte, 2))
                                          && (asm_q[WORD_W-1:BYTE_W] == $past(rx_byte)))
                else $error("R6 join order");
        end else begin : g_high_first
            assign joined = {part_q, rx_byte};
            assert_join_order_R6: assert property (@(posedge clk_phy) disable iff (!rst_phy_n)
                !slot_last ##1 slot_last |=> (asm_q[WORD_W-1:BYTE_W] == $past(rx_byte, 2))
                                          && (asm_q[BYTE_W-1:0] == $past(rx_byte)))
                else $error("R6 join order");
        end
    endgenerate

    // Hold the first byte, complete the word on the core-aligned edge.
    always_ff @(posedge clk_phy) begin
        if (!rst_phy_n) begin
            part_q <= '0;
            asm_q  <= '0;
            asm_v  <= 1'b0;
        end else if (slot_last) begin
            asm_q  <= joined;
            asm_v  <= locked;
        end else begin
            part_q <= rx_byte;
        end
    end

    // Move the completed word into the core domain.
    always_ff @(posedge clk_core) begin
        if (!rst_core_n) begin
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            word_q  <= asm_q;
            valid_q <= asm_v;
        end
    end

    assign word_out  = word_q;
    assign valid_out = valid_q;

    assert_valid_needs_lock_R2: assert property (@(posedge clk_phy) disable iff (!rst_phy_n)
        asm_v |-> locked) else $error("R2 valid before lock");

    assert_valid_sticky_R7: assert property (@(posedge clk_core)
        disable iff (!rst_core_n || !rst_phy_n)
        valid_q |=> valid_q) else $error("R7 valid dropped");
endmodule

// File: rtl/byte_gearbox.sv
`timescale 1ns/1ps
// Top: 16-bit core words to/from an 8-bit link on a clock twice as fast.
// Assumes: phase-locked 2:1 clocks with coincident rising edges; resets
// asserted and released together; inputs settle between sampling edges.
module byte_gearbox #(
    parameter int unsigned WORD_W    = gbx_pkg::GBX_WORD_W,
    parameter bit          LOW_FIRST = 1'b1
) (
    input  logic                clk_core,
    input  logic                rst_core_n,
    input  logic                clk_phy,
    input  logic                rst_phy_n,
    input  logic [WORD_W-1:0]   tx_word_i,
    output logic [WORD_W/2-1:0] tx_byte_o,
    input  logic [WORD_W/2-1:0] rx_byte_i,
    output logic [WORD_W-1:0]   rx_word_o,
    output logic                rx_valid_o
);
    logic [WORD_W-1:0] tx_hold_q;
    logic              slot_last, locked;

    // Capture the outbound word once per core cycle.
    always_ff @(posedge clk_core) begin
        if (!rst_core_n) tx_hold_q <= '0;
        else             tx_hold_q <= tx_word_i;
    end

    gbx_phase_det u_phase (
        .clk_core  (clk_core),
        .rst_core_n(rst_core_n),
        .clk_phy   (clk_phy),
        .rst_phy_n (rst_phy_n),
        .slot_last (slot_last),
        .locked    (locked)
    );

    gbx_tx #(.WORD_W(WORD_W), .LOW_FIRST(LOW_FIRST)) u_tx (
        .clk_phy  (clk_phy),
        .rst_phy_n(rst_phy_n),
        .slot_last(slot_last),
        .locked   (locked),
        .word_in  (tx_hold_q),
        .tx_byte  (tx_byte_o)
    );

    gbx_rx #(.WORD_W(WORD_W), .LOW_FIRST(LOW_FIRST)) u_rx (
        .clk_phy   (clk_phy),
        .rst_phy_n (rst_phy_n),
        .clk_core  (clk_core),
        .rst_core_n(rst_core_n),
        .slot_last (slot_last),
        .locked    (locked),
        .rx_byte   (rx_byte_i),
        .word_out  (rx_word_o),
        .valid_out (rx_valid_o)
    );
endmodule

// File: tb/tb_byte_gearbox.sv
`timescale 1ns/1ps
module tb_byte_gearbox;
    localparam int PHY_PERIOD = 4;
    localparam int N_WORDS    = 1040;
    localparam int N_RXV      = 6;
    // Directed receive vectors: {first byte, second byte, expected word}.
    localparam logic [31:0] RXV [N_RXV] = '{
        {8'h34, 8'h12, 16'h1234},
        {8'hFF, 8'h00, 16'h00FF},
        {8'h00, 8'hFF, 16'hFF00},
        {8'hA5, 8'h5A, 16'h5AA5},
        {8'h01, 8'h80, 16'h8001},
        {8'hC3, 8'h3C, 16'h3CC3}
    };

    logic        clk_core, clk_phy, rst_n, loop_en;
    logic [15:0] tx_word, rx_word;
    logic [7:0]  tx_byte, rx_drv, rx_byte;
    logic        rx_valid;
    logic [15:0] hist [N_WORDS];
    int          checks = 0, fails = 0;
    bit          done = 0;

    assign rx_byte = loop_en ? tx_byte : rx_drv;

    byte_gearbox dut (
        .clk_core(clk_core), .rst_core_n(rst_n),
        .clk_phy(clk_phy),   .rst_phy_n(rst_n),
        .tx_word_i(tx_word), .tx_byte_o(tx_byte),
        .rx_byte_i(rx_byte), .rx_word_o(rx_word), .rx_valid_o(rx_valid)
    );

    // Both clocks from one process so their rising edges share a time step.
    initial begin
        clk_phy = 0; clk_core = 0;
        forever begin
            #(PHY_PERIOD/2);
            clk_phy = ~clk_phy;
            if (clk_phy) clk_core = ~clk_core;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Step to the falling fast edge just after a core rising edge.
    task automatic to_core_slot();
        @(negedge clk_phy);
        if (!clk_core) @(negedge clk_phy);
    endtask

    task automatic check_quiet_after_release();
        for (int k = 0; k < 4; k++) begin
            @(negedge clk_phy);
            chk(tx_byte == 8'h00, "R2 tx held", {24'h0, tx_byte}, 32'h0);
            chk(rx_valid == 1'b0, "R2 rx not valid", {31'h0, rx_valid}, 32'h0);
        end
    endtask

    initial begin
        #(PHY_PERIOD * 100000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0; loop_en = 1; rx_drv = 8'h00; tx_word = 16'hA5C3;
        repeat (10) @(negedge clk_phy);
        // R1: reset state
        chk(tx_byte == 8'h00, "R1 tx reset", {24'h0, tx_byte}, 32'h0);
        chk(rx_valid == 1'b0, "R1 valid reset", {31'h0, rx_valid}, 32'h0);
        chk(rx_word == 16'h0, "R1 word reset", {16'h0, rx_word}, 32'h0);
        rst_n = 1;
        check_quiet_after_release();

        // R3 R4 R8: loopback stream with fixed latencies
        for (int i = 0; i < N_WORDS; i++)
            hist[i] = 16'(i * 40503 + 7) ^ 16'(i << 5);
        for (int i = 0; i < N_WORDS; i++) begin
            to_core_slot();
            if (i >= 12) begin
                chk(tx_byte == hist[i-2][7:0], "R4 low byte latency", {24'h0, tx_byte}, {24'h0, hist[i-2][7:0]});
                chk(rx_valid == 1'b1, "R7 valid held", {31'h0, rx_valid}, 32'h1);
                chk(rx_word == hist[i-4], "R8 loopback word", {16'h0, rx_word}, {16'h0, hist[i-4]});
            end
            tx_word = hist[i];
            @(negedge clk_phy);
            if (i >= 12)
                chk(tx_byte == hist[i-2][15:8], "R3 high byte second", {24'h0, tx_byte}, {24'h0, hist[i-2][15:8]});
        end

        // R6: directed receive byte placement
        loop_en = 0;
        for (int v = 0; v < N_RXV; v++) begin
            to_core_slot();
            rx_drv = RXV[v][31:24];
            @(negedge clk_phy);
            rx_drv = RXV[v][23:16];
            to_core_slot();
            rx_drv = 8'h00;
            to_core_slot();
            chk(rx_word == RXV[v][15:0], "R6 rx byte placement", {16'h0, rx_word}, {16'h0, RXV[v][15:0]});
        end

        // R1 R2: reset in mid-traffic, then relock quietly
        tx_word = 16'h5A5A;
        @(negedge clk_phy);
        rst_n = 0;
        repeat (3) @(negedge clk_phy);
        chk(tx_byte == 8'h00, "R1 tx reset again", {24'h0, tx_byte}, 32'h0);
        chk(rx_valid == 1'b0, "R1 valid reset again", {31'h0, rx_valid}, 32'h0);
        chk(rx_word == 16'h0, "R1 word reset again", {16'h0, rx_word}, 32'h0);
        rst_n = 1;
        check_quiet_after_release();

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule